// File: doc/BRIEF.md
# Single-Buffer Serial Port with Register Interface

This block is a serial transmitter and receiver that sits on a 32-bit register bus. Software places a byte in a one-entry transmit holding slot; a transmit engine takes it and shifts it out as a frame with one start bit, eight data bits (LSB first) and one stop bit. A receive engine watches the line, samples each bit in the middle of its bit time, and puts each complete frame into a one-entry receive slot. There is no parity, no flow control and no deeper queue.

The bit time is a whole number of clock cycles, taken from a 21-bit divider register. Values below 16 are treated as 16. Sticky flags record a byte written into an occupied transmit slot and a frame that arrives while the receive slot is still occupied. Four event bits are cleared by writing 1 to them. Three interrupt lines come out of the block: transmit, receive, and one line shared by both overrun events.

The transmit engine has four states. TX_IDLE goes to TX_START when the holding slot is full and transmit is enabled; this is the moment of the take. TX_START goes to TX_DATA after one bit time. TX_DATA stays in place for eight bit times and then goes to TX_STOP. TX_STOP goes back to TX_IDLE after one bit time. The receive engine also has four states. RX_IDLE goes to RX_START on a falling edge of the synchronised line while receive is enabled. RX_START goes to RX_DATA if the line is still low at half a bit time, and back to RX_IDLE if it is not. RX_DATA takes eight mid-bit samples and then goes to RX_STOP. RX_STOP samples the stop bit and returns to RX_IDLE; it delivers the frame only if that bit is high.

Top module: `sbuf_uart`

## Requirements
- R1: After reset, every register reads 0 (offsets 0x00 data, 0x04 status, 0x08 control, 0x0C event, 0x10 divider), the line output is high and all three interrupt outputs are low.
- R2: With control bit0 (transmit enable) set, a held byte is sent as one low start bit, eight data bits LSB first and one high stop bit. Each bit lasts the effective divider in cycles.
- R3: A write to offset 0x00 when status bit0 is 0 stores the byte and sets status bit0. A write when status bit0 is already 1 drops the byte and sets status bit2 and event bit2.
- R4: When the transmit engine takes the held byte, status bit0 clears and event bit0 sets.
- R5: With control bit1 (receive enable) set, a valid frame sets status bit1 and event bit1. A read of offset 0x00 returns the byte in bits 7:0 and clears status bit1.
- R6: A valid frame that arrives while status bit1 is 1 is dropped. The byte already held is kept, and status bit3 and event bit3 set.
- R7: Writing 1 to a bit of offset 0x0C clears that event bit. Writing 1 to status bit2 or bit3 clears that overrun flag. Writing 0 changes nothing.
- R8: A low pulse that no longer reads low at half a bit time after its falling edge is not received.
- R9: The divider sits in bits 20:0 of offset 0x10. A value below 16 produces a 16-cycle bit time.
- R10: With control bit1 clear, frames on the line are ignored and status bit1 stays 0.
- R11: The transmit interrupt is event bit0 AND control bit2. The receive interrupt is event bit1 AND control bit3. The overrun interrupt is (event bit2 AND control bit4) OR (event bit3 AND control bit5). Each line stays low while its enable bit is 0.
- R12: A frame whose stop bit reads low is dropped and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at bus_addr |
| uart_rx | input | 1 | Serial input line |
| uart_tx | output | 1 | Serial output line |
| irq_tx | output | 1 | Transmit slot free interrupt |
| irq_rx | output | 1 | Receive byte ready interrupt |
| irq_ovr | output | 1 | Shared overrun interrupt |

## Verification
The transmit overrun is the hardest case to reach. A full slot normally empties within a cycle of being written, so there is almost no time for a second write to land on it. The stimulus gets there by first clearing transmit enable, which keeps the byte parked in the slot. It then writes a second byte, and only after that sets enable again, so the scoreboard can confirm that only the first byte reaches the line. For receive overrun, two frames are driven back to back with no read between them. A start glitch shorter than half a bit time, and a frame with a low stop bit, check that the receive engine rejects bad input.

// File: rtl/sbuf_uart_pkg.sv
package sbuf_uart_pkg;

    // register byte offsets
    localparam int OFF_DATA = 'h00;
    localparam int OFF_STAT = 'h04;
    localparam int OFF_CTRL = 'h08;
    localparam int OFF_EVT  = 'h0C;
    localparam int OFF_DIV  = 'h10;

    // status / event bit positions
    localparam int B_TXFULL = 0;
    localparam int B_RXFULL = 1;
    localparam int B_TXOVR  = 2;
    localparam int B_RXOVR  = 3;

    // control bit positions
    localparam int C_TXEN    = 0;
    localparam int C_RXEN    = 1;
    localparam int C_TXIE    = 2;
    localparam int C_RXIE    = 3;
    localparam int C_TXOVRIE = 4;
    localparam int C_RXOVRIE = 5;
    localparam int CTRL_W    = 6;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

endpackage

// File: rtl/sbuf_uart_tx.sv
module sbuf_uart_tx
    import sbuf_uart_pkg::*;
#(
    parameter int DIV_W     = 21,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [DIV_W-1:0]     div_eff,
    input  logic                 hold_valid,
    input  logic [DATA_BITS-1:0] hold_data,
    output logic                 take,
    output logic                 tx_o
);
    localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    tx_state_t             st_q, st_n;
    logic [DIV_W-1:0]      cnt_q, cnt_n;
    logic [BIT_W-1:0]      bit_q, bit_n;
    logic [DATA_BITS-1:0]  sh_q, sh_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TX_IDLE;
            cnt_q <= '0;
            bit_q <= '0;
            sh_q  <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            bit_q <= bit_n;
            sh_q  <= sh_n;
        end
    end

    // next state
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        bit_n = bit_q;
        sh_n  = sh_q;
        unique case (st_q)
            TX_IDLE: begin
                if (hold_valid && en) begin
                    st_n  = TX_START;
                    cnt_n = div_eff - DIV_W'(1);
                    sh_n  = hold_data;
                end
            end
            TX_START: begin
                if (cnt_q == '0) begin
                    st_n  = TX_DATA;
                    cnt_n = div_eff - DIV_W'(1);
                    bit_n = '0;
                end else begin
                    cnt_n = cnt_q - DIV_W'(1);
                end
            end
            TX_DATA: begin
                if (cnt_q == '0) begin
                    cnt_n = div_eff - DIV_W'(1);
                    sh_n  = sh_q >> 1;
                    if (bit_q == BIT_W'(DATA_BITS - 1))
                        st_n = TX_STOP;
                    else
                        bit_n = bit_q + BIT_W'(1);
                end else begin
                    cnt_n = cnt_q - DIV_W'(1);
                end
            end
            TX_STOP: begin
                if (cnt_q == '0)
                    st_n = TX_IDLE;
                else
                    cnt_n = cnt_q - DIV_W'(1);
            end
        endcase
    end

    // outputs
    always_comb begin
        take = 1'b0;
        tx_o = 1'b1;
        unique case (st_q)
            TX_IDLE:  take = hold_valid && en;
            TX_START: tx_o = 1'b0;
            TX_DATA:  tx_o = sh_q[0];
            TX_STOP:  tx_o = 1'b1;
        endcase
    end

    // R2: the take is followed by a start bit on the line
    a_r2_start_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (tx_o == 1'b0));

endmodule

// File: rtl/sbuf_uart_rx.sv
module sbuf_uart_rx
    import sbuf_uart_pkg::*;
#(
    parameter int DIV_W     = 21,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [DIV_W-1:0]     div_eff,
    input  logic                 rx_i,
    output logic                 deliver,
    output logic [DATA_BITS-1:0] frame
);
    localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    rx_state_t             st_q, st_n;
    logic [DIV_W-1:0]      cnt_q, cnt_n;
    logic [BIT_W-1:0]      bit_q, bit_n;
    logic [DATA_BITS-1:0]  sh_q, sh_n;
    logic                  s1_q, s2_q, prev_q;
    logic                  fall;

    // line synchroniser and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q   <= rx_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign fall = prev_q && !s2_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RX_IDLE;
            cnt_q <= '0;
            bit_q <= '0;
            sh_q  <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            bit_q <= bit_n;
            sh_q  <= sh_n;
        end
    end

    // next state
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        bit_n = bit_q;
        sh_n  = sh_q;
        unique case (st_q)
            RX_IDLE: begin
                if (en && fall) begin
                    st_n  = RX_START;
                    cnt_n = (div_eff >> 1) - DIV_W'(1);
                end
            end
            RX_START: begin
                if (cnt_q == '0) begin
                    if (!s2_q) begin
                        st_n  = RX_DATA;
                        cnt_n = div_eff - DIV_W'(1);
                        bit_n = '0;
                    end else begin
                        st_n = RX_IDLE;
                    end
                end else begin
                    cnt_n = cnt_q - DIV_W'(1);
                end
            end
            RX_DATA: begin
                if (cnt_q == '0) begin
                    sh_n  = {s2_q, sh_q[DATA_BITS-1:1]};
                    cnt_n = div_eff - DIV_W'(1);
                    if (bit_q == BIT_W'(DATA_BITS - 1))
                        st_n = RX_STOP;
                    else
                        bit_n = bit_q + BIT_W'(1);
                end else begin
                    cnt_n = cnt_q - DIV_W'(1);
                end
            end
            RX_STOP: begin
                if (cnt_q == '0)
                    st_n = RX_IDLE;
                else
                    cnt_n = cnt_q - DIV_W'(1);
            end
        endcase
    end

    // outputs
    always_comb begin
        deliver = 1'b0;
        unique case (st_q)
            RX_IDLE, RX_START, RX_DATA: deliver = 1'b0;
            RX_STOP: deliver = (cnt_q == '0) && s2_q;
        endcase
    end

    assign frame = sh_q;

endmodule

// File: rtl/sbuf_uart_regs.sv
module sbuf_uart_regs
    import sbuf_uart_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DIV_W   = 21,
    parameter int MIN_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tx_take,
    input  logic              rx_deliver,
    input  logic [7:0]        rx_frame,
    output logic              tx_hold_valid,
    output logic [7:0]        tx_hold_data,
    output logic              tx_en,
    output logic              rx_en,
    output logic [DIV_W-1:0]  div_eff,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_ovr
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [3:0]        evt_q, evt_set, evt_clr;
    logic              tx_full_q, rx_full_q, tx_ovr_q, rx_ovr_q;
    logic [7:0]        tx_buf_q, rx_buf_q;
    logic              wr_data, rd_data, wr_stat, wr_ctrl, wr_evt, wr_div;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[31:DIV_W];

    assign wr_data = bus_sel && bus_wr  && (bus_addr == ADDR_W'(OFF_DATA));
    assign rd_data = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFF_DATA));
    assign wr_stat = bus_sel && bus_wr  && (bus_addr == ADDR_W'(OFF_STAT));
    assign wr_ctrl = bus_sel && bus_wr  && (bus_addr == ADDR_W'(OFF_CTRL));
    assign wr_evt  = bus_sel && bus_wr  && (bus_addr == ADDR_W'(OFF_EVT));
    assign wr_div  = bus_sel && bus_wr  && (bus_addr == ADDR_W'(OFF_DIV));

    always_comb begin
        evt_set           = '0;
        evt_set[B_TXFULL] = tx_take;
        evt_set[B_RXFULL] = rx_deliver && !rx_full_q;
        evt_set[B_TXOVR]  = wr_data && tx_full_q;
        evt_set[B_RXOVR]  = rx_deliver && rx_full_q;
        evt_clr           = wr_evt ? bus_wdata[3:0] : 4'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            div_q     <= '0;
            evt_q     <= '0;
            tx_full_q <= 1'b0;
            rx_full_q <= 1'b0;
            tx_ovr_q  <= 1'b0;
            rx_ovr_q  <= 1'b0;
            tx_buf_q  <= '0;
            rx_buf_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
            evt_q <= (evt_q & ~evt_clr) | evt_set;

            if (wr_data && !tx_full_q) begin
                tx_full_q <= 1'b1;
                tx_buf_q  <= bus_wdata[7:0];
            end else if (tx_take) begin
                tx_full_q <= 1'b0;
            end

            if (rx_deliver && !rx_full_q) begin
                rx_full_q <= 1'b1;
                rx_buf_q  <= rx_frame;
            end else if (rd_data) begin
                rx_full_q <= 1'b0;
            end

            if (wr_data && tx_full_q)
                tx_ovr_q <= 1'b1;
            else if (wr_stat && bus_wdata[B_TXOVR])
                tx_ovr_q <= 1'b0;

            if (rx_deliver && rx_full_q)
                rx_ovr_q <= 1'b1;
            else if (wr_stat && bus_wdata[B_RXOVR])
                rx_ovr_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_DATA))
            bus_rdata = 32'(rx_buf_q);
        else if (bus_addr == ADDR_W'(OFF_STAT))
            bus_rdata = 32'({rx_ovr_q, tx_ovr_q, rx_full_q, tx_full_q});
        else if (bus_addr == ADDR_W'(OFF_CTRL))
            bus_rdata = 32'(ctrl_q);
        else if (bus_addr == ADDR_W'(OFF_EVT))
            bus_rdata = 32'(evt_q);
        else if (bus_addr == ADDR_W'(OFF_DIV))
            bus_rdata = 32'(div_q);
    end

    assign div_eff       = (div_q < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_q;
    assign tx_hold_valid = tx_full_q;
    assign tx_hold_data  = tx_buf_q;
    assign tx_en         = ctrl_q[C_TXEN];
    assign rx_en         = ctrl_q[C_RXEN];

    assign irq_tx  = evt_q[B_TXFULL] && ctrl_q[C_TXIE];
    assign irq_rx  = evt_q[B_RXFULL] && ctrl_q[C_RXIE];
    assign irq_ovr = (evt_q[B_TXOVR] && ctrl_q[C_TXOVRIE]) ||
                     (evt_q[B_RXOVR] && ctrl_q[C_RXOVRIE]);

    // R3: a full slot stays full until the engine takes it
    a_r3_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full_q && !tx_take) |=> tx_full_q);

    // R3: writing into a full slot raises both overrun records
    a_r3_write_full_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && tx_full_q) |=> (tx_ovr_q && evt_q[B_TXOVR]));

    // R4: a take frees the slot and posts the transmit event
    a_r4_take_posts: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> (evt_q[B_TXFULL] && !tx_full_q));

    // R5: a delivered frame into an empty slot fills it
    a_r5_deliver_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_deliver && !rx_full_q) |=> (rx_full_q && evt_q[B_RXFULL]));

    // R6: a frame into a full slot keeps the old byte and flags overrun
    a_r6_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_deliver && rx_full_q && !rd_data) |=> (rx_full_q && rx_ovr_q && $stable(rx_buf_q)));

endmodule

// File: rtl/sbuf_uart.sv
module sbuf_uart
    import sbuf_uart_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DIV_W   = 21,
    parameter int MIN_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              uart_rx,
    output logic              uart_tx,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_ovr
);
    localparam int DATA_BITS = 8;

    logic                 take, deliver, hold_valid, tx_en, rx_en;
    logic [DATA_BITS-1:0] hold_data, frame;
    logic [DIV_W-1:0]     div_eff;

    sbuf_uart_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_take(take), .rx_deliver(deliver), .rx_frame(frame),
        .tx_hold_valid(hold_valid), .tx_hold_data(hold_data),
        .tx_en(tx_en), .rx_en(rx_en), .div_eff(div_eff),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_ovr(irq_ovr)
    );

    sbuf_uart_tx #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) tx_i (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .div_eff(div_eff),
        .hold_valid(hold_valid), .hold_data(hold_data),
        .take(take), .tx_o(uart_tx)
    );

    sbuf_uart_rx #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) rx_i (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .div_eff(div_eff),
        .rx_i(uart_rx), .deliver(deliver), .frame(frame)
    );

endmodule

// File: tb/sbuf_uart_tb_top.sv
module sbuf_uart_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        uart_rx = 1'b1, uart_tx, irq_tx, irq_rx, irq_ovr;

    int          total = 0, bad = 0;
    int          bit_cyc = 16;
    logic [7:0]  exp_q[$];
    logic [31:0] rv;

    always #4 clk = ~clk;   // 125 MHz

    sbuf_uart dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .uart_rx(uart_rx), .uart_tx(uart_tx),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_ovr(irq_ovr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // driver for the serial input line
    task automatic send_frame(input logic [7:0] b, input logic stop_lvl);
        @(negedge clk);
        uart_rx = 1'b0;
        repeat (bit_cyc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            uart_rx = b[i];
            repeat (bit_cyc) @(negedge clk);
        end
        uart_rx = stop_lvl;
        repeat (bit_cyc) @(negedge clk);
        uart_rx = 1'b1;
        repeat (bit_cyc) @(negedge clk);
    endtask

    // driver for the transmit side: queue the expectation, then write
    task automatic queue_byte(input logic [7:0] b);
        exp_q.push_back(b);
        bus_write(5'h00, 32'(b));
    endtask

    task automatic wait_tx_drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // monitor: decode frames on the output line and compare (R2)
    initial begin
        logic [7:0] got;
        wait (rst_n === 1'b1);
        forever begin
            @(negedge uart_tx);
            repeat (bit_cyc / 2) @(negedge clk);
            check("R2 start bit", 32'(uart_tx), 32'h0);
            for (int i = 0; i < 8; i++) begin
                repeat (bit_cyc) @(negedge clk);
                got[i] = uart_tx;
            end
            repeat (bit_cyc) @(negedge clk);
            check("R2 stop bit", 32'(uart_tx), 32'h1);
            if (exp_q.size() == 0) begin
                check("R2 unexpected frame", 32'(got), 32'hFFFF_FFFF);
            end else begin
                check("R2 frame byte", 32'(got), 32'(exp_q.pop_front()));
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        bus_read(5'h04, rv); check("R1 status", rv, 32'h0);
        bus_read(5'h08, rv); check("R1 control", rv, 32'h0);
        bus_read(5'h0C, rv); check("R1 events", rv, 32'h0);
        bus_read(5'h10, rv); check("R1 divider", rv, 32'h0);
        bus_read(5'h00, rv); check("R1 data", rv, 32'h0);
        check("R1 line", 32'(uart_tx), 32'h1);
        check("R1 irqs", 32'({irq_tx, irq_rx, irq_ovr}), 32'h0);

        // R9 divider below minimum acts as 16; R2 basic send; R4 event
        bus_write(5'h10, 32'd5);
        bit_cyc = 16;
        bus_write(5'h08, 32'h05);
        queue_byte(8'hA5);
        wait_tx_drain();
        bus_read(5'h0C, rv); check("R4 event bit0 after take", rv, 32'h1);
        check("R4 R11 irq_tx enabled", 32'(irq_tx), 32'h1);
        bus_read(5'h04, rv); check("R4 slot empty", rv, 32'h0);
        // R7 write-one-to-clear
        bus_write(5'h0C, 32'h1);
        bus_read(5'h0C, rv); check("R7 event cleared", rv, 32'h0);
        check("R7 irq_tx dropped", 32'(irq_tx), 32'h0);

        // R2 other divider, back-to-back bytes
        bus_write(5'h10, 32'd37);
        bit_cyc = 37;
        queue_byte(8'h5A);
        rv = 32'h1;
        while (rv[0]) bus_read(5'h04, rv);
        queue_byte(8'hC3);
        wait_tx_drain();

        // R3 transmit overrun with engine held off
        bus_write(5'h10, 32'd16);
        bit_cyc = 16;
        bus_write(5'h08, 32'h10);
        bus_write(5'h0C, 32'hF);
        exp_q.push_back(8'h11);
        bus_write(5'h00, 32'h11);
        bus_read(5'h04, rv); check("R3 slot full", rv, 32'h1);
        bus_write(5'h00, 32'h22);
        bus_read(5'h04, rv); check("R3 overrun status", rv, 32'h5);
        bus_read(5'h0C, rv); check("R3 overrun event", rv, 32'h4);
        check("R11 irq_ovr from tx overrun", 32'(irq_ovr), 32'h1);
        bus_write(5'h08, 32'h11);
        wait_tx_drain();
        bus_read(5'h04, rv); check("R3 only first byte sent, flag sticky", rv, 32'h4);
        bus_write(5'h04, 32'h4);
        bus_read(5'h04, rv); check("R7 status overrun cleared", rv, 32'h0);
        bus_write(5'h0C, 32'h0);
        bus_read(5'h0C, rv); check("R7 zero write no effect", rv, 32'h5);
        bus_write(5'h0C, 32'h5);
        bus_read(5'h0C, rv); check("R7 events cleared", rv, 32'h0);
        check("R7 irq_ovr dropped", 32'(irq_ovr), 32'h0);

        // R5 receive
        bus_write(5'h08, 32'h0A);
        send_frame(8'h96, 1'b1);
        bus_read(5'h04, rv); check("R5 rx full", rv, 32'h2);
        bus_read(5'h0C, rv); check("R5 rx event", rv, 32'h2);
        check("R5 irq_rx", 32'(irq_rx), 32'h1);
        bus_read(5'h00, rv); check("R5 rx byte", rv, 32'h96);
        bus_read(5'h04, rv); check("R5 read clears full", rv, 32'h0);
        bus_write(5'h0C, 32'hF);

        // R6 receive overrun
        bus_write(5'h08, 32'h2A);
        send_frame(8'h41, 1'b1);
        send_frame(8'h42, 1'b1);
        bus_read(5'h04, rv); check("R6 status full+overrun", rv, 32'hA);
        bus_read(5'h0C, rv); check("R6 events", rv, 32'hA);
        check("R6 irq_ovr", 32'(irq_ovr), 32'h1);
        bus_read(5'h00, rv); check("R6 old byte kept", rv, 32'h41);
        bus_write(5'h04, 32'h8);
        bus_write(5'h0C, 32'hF);
        bus_read(5'h04, rv); check("R7 rx overrun cleared", rv, 32'h0);

        // R8 short start glitch
        @(negedge clk); uart_rx = 1'b0;
        repeat (3) @(negedge clk); uart_rx = 1'b1;
        repeat (40) @(negedge clk);
        bus_read(5'h04, rv); check("R8 glitch rejected", rv, 32'h0);
        send_frame(8'h7E, 1'b1);
        bus_read(5'h00, rv); check("R8 next frame ok", rv, 32'h7E);

        // R12 low stop bit
        send_frame(8'h3C, 1'b0);
        bus_read(5'h04, rv); check("R12 bad stop dropped", rv, 32'h0);
        bus_read(5'h0C, rv); check("R12 no event", rv, 32'h2);
        bus_write(5'h0C, 32'hF);

        // R10 receive disabled
        bus_write(5'h08, 32'h00);
        send_frame(8'h55, 1'b1);
        bus_read(5'h04, rv); check("R10 disabled rx ignored", rv, 32'h0);

        // R11 gating with enables off
        bus_write(5'h08, 32'h02);
        send_frame(8'h33, 1'b1);
        bus_read(5'h0C, rv); check("R11 event set", rv, 32'h2);
        check("R11 irq_rx gated", 32'(irq_rx), 32'h0);
        bus_read(5'h00, rv);

        // R5 at a larger divider
        bus_write(5'h10, 32'd50);
        bit_cyc = 50;
        send_frame(8'hE1, 1'b1);
        bus_read(5'h00, rv); check("R5 rx byte div 50", rv, 32'hE1);
        check("R2 no stray frames", 32'(exp_q.size()), 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule